// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the configurable heart of a small programmable-logic device. It takes a set of dedicated inputs and a set of feedback signals, and builds the true and inverted form of each one as array lines. A bank of programmable AND terms then reads those lines through a stored connection map. Fixed OR gates merge contiguous groups of terms into one logic sum per output. The groups differ in size: they grow from both ends of the output range toward the middle. The same array also yields one enable term per output, one shared preset term and one shared clear term. Output macrocells and pin drivers sit outside and consume these signals.

The connection map is loaded one term row at a time through a valid/ready write port. The port applies no back-pressure. `wr_ready` is low only while reset is held and in the first cycle after it. After that it stays high, and a writer may present one row every cycle. A lock request sets a sticky security bit. From then on, writes are discarded and the readback port returns zeros until the next reset. Term evaluation is purely combinational from the inputs and the stored map.

Top module: `pal_sop_core`

## Requirements
- R1: A term row with no connection bits set evaluates to 1, so after reset every sum, every enable term, the preset term and the clear term are all 1.
- R2: A term is the AND of every array line whose map bit is 1. Line 2j carries signal j and line 2j+1 carries its inverse. Signals 0..N_IN-1 are `ded_in`, and signals N_IN.. are `fb_in`.
- R3: A term row that connects both polarities of the same signal evaluates to 0 for every input value.
- R4: Output k ORs a contiguous group of BASE_TERMS+STEP_TERMS*min(k, N_OUT-1-k) term rows. The groups are laid out in output order from row 0.
- R5: The enable term of output k is row S+k, where S is the total of the sum terms. The preset term is row S+N_OUT and the clear term is row S+N_OUT+1.
- R6: A write accepted while unlocked replaces the addressed row from the next clock edge. A write whose address is not below the row count, or whose `wr_valid` is low, changes no row.
- R7: `lock_req` sets `locked` at the next edge, and `locked` stays set until reset. A write in the same cycle as the lock request still takes effect. Writes in later cycles are ignored.
- R8: When unlocked, `rd_row` combinationally returns the row at `rd_addr`, or zero for an out-of-range address. When locked, it returns zero.
- R9: Reset clears every row and the lock, and holds `wr_ready` low. `wr_ready` rises at the first clock edge after reset is released.
- R10: Once high, `wr_ready` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ded_in | input | N_IN | Dedicated input signals |
| fb_in | input | N_FB | Feedback signals from the output cells |
| wr_valid | input | 1 | Row write request |
| wr_ready | output | 1 | Write port ready (no back-pressure after reset) |
| wr_addr | input | AW | Term row index to write |
| wr_row | input | NL | Connection bits for the row, one per array line |
| lock_req | input | 1 | Request to set the security lock |
| locked | output | 1 | Security lock state |
| rd_addr | input | AW | Term row index to read back |
| rd_row | output | NL | Readback data, zero while locked |
| sum_out | output | N_OUT | Logic sum per output |
| oe_term | output | N_OUT | Enable term per output |
| preset_term | output | 1 | Shared preset term |
| reset_term | output | 1 | Shared clear term |

## Verification
The bench builds the block with 3 dedicated inputs, 2 feedback signals, 3 outputs, a base group of 2 terms and a step of 2. This gives groups of 2, 4 and 2 terms, a 10-line array and 13 rows. At that size every one of the 32 input combinations can be swept under several complete maps. Every row can be read back, and the unused addresses 13 to 15 are reachable for out-of-range writes. Both the empty-row case and the both-polarity case sit in known rows, so group boundaries, the control-term rows and the behaviour before and after locking are all checked directly against an arithmetic model.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Number of sum terms feeding output k: grows toward the middle.
  function automatic int grp_size(input int k, input int n_out,
                                  input int base, input int step);
    int m;
    m = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return base + step * m;
  endfunction

  // First term row of output k's group.
  function automatic int grp_base(input int k, input int n_out,
                                  input int base, input int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_size(j, n_out, base, step);
    return acc;
  endfunction

  // Total number of sum terms across all outputs.
  function automatic int sum_total(input int n_out, input int base,
                                   input int step);
    return grp_base(n_out, n_out, base, step);
  endfunction

endpackage

// File: rtl/pal_line_gen.sv
module pal_line_gen #(
  parameter int N_IN = 12,
  parameter int N_FB = 10,
  localparam int NS  = N_IN + N_FB,
  localparam int NL  = 2 * NS
) (
  input  logic [N_IN-1:0] ded_in,
  input  logic [N_FB-1:0] fb_in,
  output logic [NL-1:0]   lines
);
  logic [NS-1:0] sig;
  assign sig = {fb_in, ded_in};

  for (genvar j = 0; j < NS; j++) begin : g_line
    assign lines[2*j]   = sig[j];
    assign lines[2*j+1] = ~sig[j];
  end
endmodule

// File: rtl/pal_map_store.sv
module pal_map_store #(
  parameter int N_ROWS = 132,
  parameter int ROW_W  = 44,
  parameter int AW     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [ROW_W-1:0]              wr_row,
  input  logic                          lock_req,
  output logic                          locked,
  input  logic [AW-1:0]                 rd_addr,
  output logic [ROW_W-1:0]              rd_row,
  output logic [N_ROWS-1:0][ROW_W-1:0]  map_q
);
  localparam logic [AW:0] ROWS_L = N_ROWS[AW:0];

  logic ready_q, lock_q;
  logic wr_ok;
  logic rd_in_range;

  assign wr_ok = wr_valid && ready_q && !lock_q &&
                 ({1'b0, wr_addr} < ROWS_L);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (lock_req) lock_q <= 1'b1;
    end
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[r] <= '0;
      else if (wr_ok && (wr_addr == r[AW-1:0]))
        map_q[r] <= wr_row;
    end
  end

  assign rd_in_range = ({1'b0, rd_addr} < ROWS_L);
  assign rd_row      = (!lock_q && rd_in_range) ? map_q[rd_addr] : '0;
  assign wr_ready    = ready_q;
  assign locked      = lock_q;
endmodule

// File: rtl/pal_term_eval.sv
module pal_term_eval #(
  parameter int N_ROWS = 132,
  parameter int ROW_W  = 44
) (
  input  logic [ROW_W-1:0]              lines,
  input  logic [N_ROWS-1:0][ROW_W-1:0]  map_q,
  output logic [N_ROWS-1:0]             terms
);
  // A term is high when every connected line is high; no connection -> 1.
  for (genvar t = 0; t < N_ROWS; t++) begin : g_term
    assign terms[t] = &(~map_q[t] | lines);
  end
endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
  parameter int N_OUT      = 10,
  parameter int BASE_TERMS = 8,
  parameter int STEP_TERMS = 2,
  parameter int N_SUMS     = 120
) (
  input  logic [N_SUMS-1:0] terms,
  output logic [N_OUT-1:0]  sums
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_or
    localparam int B = pal_pkg::grp_base(k, N_OUT, BASE_TERMS, STEP_TERMS);
    localparam int S = pal_pkg::grp_size(k, N_OUT, BASE_TERMS, STEP_TERMS);
    assign sums[k] = |terms[B +: S];
  end
endmodule

// File: rtl/pal_sop_core.sv
module pal_sop_core #(
  parameter int N_IN       = 12,
  parameter int N_FB       = 10,
  parameter int N_OUT      = 10,
  parameter int BASE_TERMS = 8,
  parameter int STEP_TERMS = 2,
  localparam int NL        = 2 * (N_IN + N_FB),
  localparam int N_SUMS    = pal_pkg::sum_total(N_OUT, BASE_TERMS, STEP_TERMS),
  localparam int N_ROWS    = N_SUMS + N_OUT + 2,
  localparam int AW        = $clog2(N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   ded_in,
  input  logic [N_FB-1:0]   fb_in,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NL-1:0]     wr_row,
  input  logic              lock_req,
  output logic              locked,
  input  logic [AW-1:0]     rd_addr,
  output logic [NL-1:0]     rd_row,
  output logic [N_OUT-1:0]  sum_out,
  output logic [N_OUT-1:0]  oe_term,
  output logic              preset_term,
  output logic              reset_term
);
  logic [NL-1:0]              lines;
  logic [N_ROWS-1:0][NL-1:0]  map_q;
  logic [N_ROWS-1:0]          terms;

  pal_line_gen #(.N_IN(N_IN), .N_FB(N_FB)) u_lines (
    .ded_in (ded_in),
    .fb_in  (fb_in),
    .lines  (lines)
  );

  pal_map_store #(.N_ROWS(N_ROWS), .ROW_W(NL), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_row   (wr_row),
    .lock_req (lock_req),
    .locked   (locked),
    .rd_addr  (rd_addr),
    .rd_row   (rd_row),
    .map_q    (map_q)
  );

  pal_term_eval #(.N_ROWS(N_ROWS), .ROW_W(NL)) u_terms (
    .lines (lines),
    .map_q (map_q),
    .terms (terms)
  );

  pal_or_plane #(
    .N_OUT      (N_OUT),
    .BASE_TERMS (BASE_TERMS),
    .STEP_TERMS (STEP_TERMS),
    .N_SUMS     (N_SUMS)
  ) u_or (
    .terms (terms[N_SUMS-1:0]),
    .sums  (sum_out)
  );

  assign oe_term     = terms[N_SUMS +: N_OUT];
  assign preset_term = terms[N_SUMS + N_OUT];
  assign reset_term  = terms[N_SUMS + N_OUT + 1];
endmodule

// File: rtl/pal_sop_core_chk.sv
module pal_sop_core_chk #(
  parameter int N_IN  = 12,
  parameter int N_FB  = 10,
  parameter int N_OUT = 10,
  parameter int NL    = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_IN-1:0]  ded_in,
  input logic [N_FB-1:0]  fb_in,
  input logic             lock_req,
  input logic             locked,
  input logic             wr_ready,
  input logic [NL-1:0]    rd_row,
  input logic [N_OUT-1:0] sum_out
);
  // R7: a lock request takes hold at the next edge
  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> locked);

  // R7: the lock never clears without reset
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7: with the map frozen and inputs unchanged, sums do not move
  p_frozen_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && $stable(ded_in) && $stable(fb_in))
      |-> $stable(sum_out));

  // R8: readback is hidden while locked
  p_rd_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (rd_row == '0));

  // R10: no back-pressure once ready
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready);
endmodule

bind pal_sop_core pal_sop_core_chk #(
  .N_IN(N_IN), .N_FB(N_FB), .N_OUT(N_OUT), .NL(NL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
  .lock_req(lock_req), .locked(locked), .wr_ready(wr_ready),
  .rd_row(rd_row), .sum_out(sum_out)
);

// File: tb/pal_sop_core_tb.sv
module pal_sop_core_tb;
  localparam int N_IN = 3, N_FB = 2, N_OUT = 3, BT = 2, ST = 2;
  localparam int NL = 10, NR = 13, AW = 4, NS_SUM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IN-1:0] ded_in = '0;
  logic [N_FB-1:0] fb_in = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [NL-1:0] wr_row = '0;
  logic lock_req = 1'b0;
  logic locked;
  logic [AW-1:0] rd_addr = '0;
  logic [NL-1:0] rd_row;
  logic [N_OUT-1:0] sum_out, oe_term;
  logic preset_term, reset_term;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [NL-1:0] em [NR];

  always #2 clk = ~clk;

  pal_sop_core #(.N_IN(N_IN), .N_FB(N_FB), .N_OUT(N_OUT),
                 .BASE_TERMS(BT), .STEP_TERMS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_row(wr_row), .lock_req(lock_req), .locked(locked),
    .rd_addr(rd_addr), .rd_row(rd_row), .sum_out(sum_out),
    .oe_term(oe_term), .preset_term(preset_term), .reset_term(reset_term)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic tval(input logic [NL-1:0] row, input logic [4:0] s);
    logic [NL-1:0] ln;
    for (int j = 0; j < 5; j++) begin
      ln[2*j]   = s[j];
      ln[2*j+1] = ~s[j];
    end
    return &(~row | ln);
  endfunction

  // {reset, preset, oe[2:0], sum[2:0]} from the bench's own map copy
  function automatic logic [7:0] model(input logic [4:0] s);
    logic [7:0] r;
    int b;
    r = '0;
    b = 0;
    for (int k = 0; k < N_OUT; k++) begin
      int m, sz;
      m = (k < N_OUT - 1 - k) ? k : N_OUT - 1 - k;
      sz = BT + ST * m;
      for (int t = b; t < b + sz; t++) r[k] = r[k] | tval(em[t], s);
      b += sz;
    end
    for (int k = 0; k < N_OUT; k++) r[3+k] = tval(em[b+k], s);
    r[6] = tval(em[b+N_OUT], s);
    r[7] = tval(em[b+N_OUT+1], s);
    return r;
  endfunction

  task automatic wr(input int a, input logic [NL-1:0] d, input bit v);
    @(negedge clk);
    wr_valid = v; wr_addr = a[AW-1:0]; wr_row = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      {fb_in, ded_in} = s[4:0];
      #1;
      chk(req, {24'd0, reset_term, preset_term, oe_term, sum_out},
          {24'd0, model(s[4:0])});
    end
  endtask

  task automatic readback(input string req, input bit hidden);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      rd_addr = a[AW-1:0];
      #1;
      chk(req, {22'd0, rd_row},
          {22'd0, (hidden || a >= NR) ? {NL{1'b0}} : em[a]});
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 ready low in reset", {31'd0, wr_ready}, 32'd0);
    chk("R9 unlocked in reset", {31'd0, locked}, 32'd0);
    rst_n = 1'b1;
    for (int t = 0; t < NR; t++) em[t] = '0;
    @(negedge clk);
    chk("R9 ready after reset", {31'd0, wr_ready}, 32'd1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: empty map, every term high
    sweep("R1 empty rows");
    readback("R9 cleared map", 1'b0);

    // Pattern A: row 0 empty, row 1 both polarities of signal 0 (R3)
    for (int t = 0; t < NR; t++) begin
      logic [NL-1:0] d;
      if (t == 0) d = '0;
      else if (t == 1) d = 10'b0000000011;
      else d = (10'd1 << ((t * 3) % NL)) | (10'd1 << ((t * 7 + 4) % NL));
      em[t] = d;
      wr(t, d, 1'b1);
    end
    readback("R6 R8 pattern A", 1'b0);
    sweep("R2 R3 R4 R5 pattern A");

    // Row 0 holds both polarities of signal 4: group 0 now depends on row 1 only
    em[0] = 10'b1100000000;
    wr(0, em[0], 1'b1);
    em[1] = 10'b0000000011;
    @(negedge clk);
    #1;
    chk("R3 both-polarity rows drop group 0", {31'd0, sum_out[0]}, 32'd0);
    sweep("R3 R4 group 0 dead");

    // Pattern B: single-line rows, rotating, to isolate group boundaries
    for (int t = 0; t < NR; t++) begin
      em[t] = 10'd1 << ((t * 5 + 1) % NL);
      wr(t, em[t], 1'b1);
    end
    sweep("R2 R4 R5 pattern B");

    // R6: out-of-range and non-valid writes change nothing
    wr(13, 10'h3ff, 1'b1);
    wr(15, 10'h3ff, 1'b1);
    wr(2, 10'h3ff, 1'b0);
    readback("R6 ignored writes", 1'b0);
    sweep("R6 outputs unchanged");

    // R7: write in the lock cycle still lands
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd12; wr_row = 10'b0000000100; lock_req = 1'b1;
    em[12] = 10'b0000000100;
    @(negedge clk);
    wr_valid = 1'b0; lock_req = 1'b0;
    chk("R7 locked after request", {31'd0, locked}, 32'd1);
    wr(5, 10'h3ff, 1'b1);
    wr(12, 10'h000, 1'b1);
    chk("R10 ready while locked", {31'd0, wr_ready}, 32'd1);
    readback("R8 hidden when locked", 1'b1);
    sweep("R7 writes ignored after lock");

    // Reset clears lock and map
    do_reset();
    chk("R9 lock cleared", {31'd0, locked}, 32'd0);
    readback("R9 map cleared again", 1'b0);
    sweep("R1 empty after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule